// File: doc/BRIEF.md
# Bin-Major Track List Merger

This block gathers binned track lists from a row of front-end sectors and joins them into one list for a downstream processor. Each sector offers one FIFO read port per momentum bin. The block selects a bin with `req_bin` and holds a one-hot token on `token`. Only the token holder is read. The holder is drained of its tracks in the selected bin, and then the token moves to the next sector. When every active sector has been visited, the bin drops by one and the sweep starts again at sector 0. Bin `NUM_BINS-1` is the highest bin and is swept first.

The number of active sectors is a run-time input, sampled on `start`, so the same block can serve a 13-sector region or a 14-sector region. The output is a valid/last stream with no backpressure. Each word carries the track payload, the sector it came from and its bin. The list stops after `CAP` words (48 by default). If any track was still unread when the cap was reached, the `truncated` flag is set.

The controller is a four-state machine:
- **IDLE** goes to **TOKEN** on `start`. This transition loads the pointers and clears the count and the flag.
- **TOKEN** reads one track per cycle from the holder. When the holder is empty, the token moves on after that single cycle. TOKEN goes to **FLUSH** after the last position, or on the read that reaches the cap.
- **FLUSH** sends the staged final word with `out_last`. It then goes to **SCAN** if the cap was reached, otherwise to IDLE.
- **SCAN** continues the token walk without reading. It goes to IDLE as soon as it finds a non-empty holder, which sets `truncated`, or when the walk ends.

Top module: `bin_list_merger`

## Requirements
- R1: Bins are emitted from bin NUM_BINS-1 down to bin 0. Within each bin, sectors are emitted in ascending order from 0 to N-1, where N is the active sector count.
- R2: The tracks of one sector and one bin leave in the order that sector's read port presented them. They are not reordered.
- R3: At most CAP (48) words are emitted per run. `out_last` is high on the final word, whether the list ran out or hit the cap. No word follows it before the next `start`.
- R4: At most one bit of `token` is high at a time. A `pop` bit is raised only for the token holder, and only when its `src_empty` bit is low.
- R5: A holder that is empty in the current bin keeps the token for exactly one cycle and produces no word. With T tracks read and T below CAP, `busy` stays high for 4·N+T+1 cycles when NUM_BINS is 4.
- R6: Each word carries the payload in `out_track`, the source sector index in `out_sector` and the bin index in `out_bin`.
- R7: `truncated` is cleared on `start`. It is set if any track remains unread when the cap is reached, and it holds once `busy` is low.
- R8: `active_sectors` is sampled on `start`, with 0 treated as 1 and values above MAX_SECTORS treated as MAX_SECTORS. Sectors at or above that count never receive the token.
- R9: After reset, `busy`, `out_valid`, `token`, `pop` and `truncated` are all low.
- R10: A run in which every sector is empty in every bin emits no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a merge run; taken only when idle |
| active_sectors | input | $clog2(MAX_SECTORS+1) | Number of sectors taking part in the run |
| src_empty | input | MAX_SECTORS | Per-sector empty flag for bin `req_bin` |
| src_data | input | MAX_SECTORS*TRK_W | Per-sector head track for bin `req_bin`, flattened |
| req_bin | output | $clog2(NUM_BINS) | Bin currently being read |
| token | output | MAX_SECTORS | One-hot token holder |
| pop | output | MAX_SECTORS | Per-sector read strobe |
| out_valid | output | 1 | Output word valid |
| out_last | output | 1 | Final word of the list |
| out_sector | output | $clog2(MAX_SECTORS) | Source sector of the word |
| out_bin | output | $clog2(NUM_BINS) | Bin of the word |
| out_track | output | TRK_W | Track payload |
| busy | output | 1 | A run is in progress |
| truncated | output | 1 | Tracks were left unsent at the cap |

## Verification
The bench models every sector's per-bin FIFO. It sweeps the occupancy patterns listed below and rebuilds the expected word list arithmetically for each run.
- **All empty.** Separates R10 and the one-cycle release timing of R5 from the data path.
- **One track everywhere, with 12 sectors and with 13 sectors.** Lands exactly on the cap (48) and one sector past it, which tells a correctly placed `out_last` from an off-by-one, and `truncated` low from high.
- **Modular occupancy patterns at sector counts of 1, 3, 13, 14 and 16.** Expose wrong bin or sector order and wrap errors in the pointer.
- **A single sector holding more than the cap in one bin.** Shows that truncation can stop in the middle of one sector's list.

// File: rtl/lmrg_pkg.sv
package lmrg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TOKEN = 2'd1,
        ST_FLUSH = 2'd2,
        ST_SCAN  = 2'd3
    } mrg_state_t;
endpackage

// File: rtl/lmrg_ring.sv
// Sector/bin walk pointer and one-hot token decoder.
module lmrg_ring #(
    parameter int MAX_SECTORS = 16,
    parameter int NUM_BINS    = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic                               step,
    input  logic                               grant_en,
    input  logic [$clog2(MAX_SECTORS+1)-1:0]   active_n,
    output logic [$clog2(MAX_SECTORS)-1:0]     sec,
    output logic [$clog2(NUM_BINS)-1:0]        bin,
    output logic                               at_end,
    output logic [MAX_SECTORS-1:0]             token
);
    localparam int SEC_W = $clog2(MAX_SECTORS);
    localparam int CNT_W = $clog2(MAX_SECTORS+1);
    localparam int BIN_W = $clog2(NUM_BINS);

    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] act_clamped;
    logic             sec_last;

    always_comb begin
        if (active_n == '0)
            act_clamped = CNT_W'(1);
        else if (active_n > CNT_W'(MAX_SECTORS))
            act_clamped = CNT_W'(MAX_SECTORS);
        else
            act_clamped = active_n;
    end

    assign sec_last = ((CNT_W'(sec) + CNT_W'(1)) == act_q);
    assign at_end   = sec_last && (bin == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec   <= '0;
            bin   <= '0;
            act_q <= CNT_W'(1);
        end else if (load) begin
            sec   <= '0;
            bin   <= BIN_W'(NUM_BINS-1);
            act_q <= act_clamped;
        end else if (step) begin
            if (sec_last) begin
                sec <= '0;
                if (bin != '0)
                    bin <= bin - BIN_W'(1);
            end else begin
                sec <= sec + SEC_W'(1);
            end
        end
    end

    generate
        for (genvar g = 0; g < MAX_SECTORS; g++) begin : g_tok
            assign token[g] = grant_en && (sec == SEC_W'(g));
        end
    endgenerate

    // R4
    token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(token));

    // R8
    token_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_en |-> (CNT_W'(sec) < act_q));
endmodule

// File: rtl/lmrg_stage.sv
// One-word staging register, so the final word can be marked last.
module lmrg_stage #(
    parameter int TRK_W = 16,
    parameter int SEC_W = 4,
    parameter int BIN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [SEC_W-1:0] in_sector,
    input  logic [BIN_W-1:0] in_bin,
    input  logic [TRK_W-1:0] in_track,
    input  logic             flush,
    output logic             out_valid,
    output logic             out_last,
    output logic [SEC_W-1:0] out_sector,
    output logic [BIN_W-1:0] out_bin,
    output logic [TRK_W-1:0] out_track
);
    logic             stg_vld;
    logic [SEC_W-1:0] stg_sector;
    logic [BIN_W-1:0] stg_bin;
    logic [TRK_W-1:0] stg_track;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_vld    <= 1'b0;
            stg_sector <= '0;
            stg_bin    <= '0;
            stg_track  <= '0;
        end else if (clear) begin
            stg_vld <= 1'b0;
        end else if (load) begin
            stg_vld    <= 1'b1;
            stg_sector <= in_sector;
            stg_bin    <= in_bin;
            stg_track  <= in_track;
        end else if (flush) begin
            stg_vld <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            out_sector <= '0;
            out_bin    <= '0;
            out_track  <= '0;
        end else begin
            out_valid <= stg_vld && !clear && (load || flush);
            out_last  <= stg_vld && !clear && flush && !load;
            if (stg_vld && (load || flush)) begin
                out_sector <= stg_sector;
                out_bin    <= stg_bin;
                out_track  <= stg_track;
            end
        end
    end

    // Checker state: the bin of the previous word in this run.
    logic [BIN_W-1:0] prev_bin;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_bin <= '1;
        else if (clear)
            prev_bin <= '1;
        else if (out_valid)
            prev_bin <= out_bin;
    end

    // R1
    bin_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bin <= prev_bin));

    // R3
    last_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> !out_valid);

    // R3
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: rtl/lmrg_fsm.sv
// Run controller: token walk, cap counting, flush and truncation scan.
module lmrg_fsm
    import lmrg_pkg::*;
#(
    parameter int CAP = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic head_empty,
    input  logic at_end,
    output logic load,
    output logic step,
    output logic grant_en,
    output logic pop_en,
    output logic flush,
    output logic busy,
    output logic truncated
);
    localparam int SENT_W = $clog2(CAP+1);

    mrg_state_t        state, state_nx;
    logic [SENT_W-1:0] sent;
    logic              set_trunc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        load      = 1'b0;
        step      = 1'b0;
        grant_en  = 1'b0;
        pop_en    = 1'b0;
        flush     = 1'b0;
        set_trunc = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load     = 1'b1;
                    state_nx = ST_TOKEN;
                end
            end
            ST_TOKEN: begin
                grant_en = 1'b1;
                if (!head_empty) begin
                    pop_en = 1'b1;
                    if (sent == SENT_W'(CAP-1))
                        state_nx = ST_FLUSH;
                end else if (at_end) begin
                    state_nx = ST_FLUSH;
                end else begin
                    step = 1'b1;
                end
            end
            ST_FLUSH: begin
                flush    = 1'b1;
                state_nx = (sent == SENT_W'(CAP)) ? ST_SCAN : ST_IDLE;
            end
            ST_SCAN: begin
                grant_en = 1'b1;
                if (!head_empty) begin
                    set_trunc = 1'b1;
                    state_nx  = ST_IDLE;
                end else if (at_end) begin
                    state_nx = ST_IDLE;
                end else begin
                    step = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent      <= '0;
            truncated <= 1'b0;
        end else if (load) begin
            sent      <= '0;
            truncated <= 1'b0;
        end else begin
            if (pop_en)
                sent <= sent + SENT_W'(1);
            if (set_trunc)
                truncated <= 1'b1;
        end
    end

    assign busy = (state != ST_IDLE);

    // R3
    cap_not_exceeded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> (sent < SENT_W'(CAP)));

    // R7
    trunc_only_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(truncated) |-> ($past(sent) == SENT_W'(CAP)));
endmodule

// File: rtl/bin_list_merger.sv
module bin_list_merger #(
    parameter int MAX_SECTORS = 16,
    parameter int NUM_BINS    = 4,
    parameter int TRK_W       = 16,
    parameter int CAP         = 48
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [$clog2(MAX_SECTORS+1)-1:0]     active_sectors,
    input  logic [MAX_SECTORS-1:0]               src_empty,
    input  logic [MAX_SECTORS*TRK_W-1:0]         src_data,
    output logic [$clog2(NUM_BINS)-1:0]          req_bin,
    output logic [MAX_SECTORS-1:0]               token,
    output logic [MAX_SECTORS-1:0]               pop,
    output logic                                 out_valid,
    output logic                                 out_last,
    output logic [$clog2(MAX_SECTORS)-1:0]       out_sector,
    output logic [$clog2(NUM_BINS)-1:0]          out_bin,
    output logic [TRK_W-1:0]                     out_track,
    output logic                                 busy,
    output logic                                 truncated
);
    localparam int SEC_W = $clog2(MAX_SECTORS);
    localparam int BIN_W = $clog2(NUM_BINS);

    logic             load, step, grant_en, pop_en, flush;
    logic             head_empty, at_end;
    logic [SEC_W-1:0] sec;
    logic [BIN_W-1:0] bin;
    logic [TRK_W-1:0] head_data;

    lmrg_fsm #(.CAP(CAP)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .head_empty(head_empty),
        .at_end    (at_end),
        .load      (load),
        .step      (step),
        .grant_en  (grant_en),
        .pop_en    (pop_en),
        .flush     (flush),
        .busy      (busy),
        .truncated (truncated)
    );

    lmrg_ring #(.MAX_SECTORS(MAX_SECTORS), .NUM_BINS(NUM_BINS)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .grant_en(grant_en),
        .active_n(active_sectors),
        .sec     (sec),
        .bin     (bin),
        .at_end  (at_end),
        .token   (token)
    );

    always_comb begin
        head_empty = src_empty[sec];
        head_data  = src_data[sec*TRK_W +: TRK_W];
    end

    assign req_bin = bin;
    assign pop     = token & ~src_empty & {MAX_SECTORS{pop_en}};

    lmrg_stage #(.TRK_W(TRK_W), .SEC_W(SEC_W), .BIN_W(BIN_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (load),
        .load      (pop_en),
        .in_sector (sec),
        .in_bin    (bin),
        .in_track  (head_data),
        .flush     (flush),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_sector(out_sector),
        .out_bin   (out_bin),
        .out_track (out_track)
    );

    // R4
    pop_to_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pop & ~token) == '0) && ((pop & src_empty) == '0));

    // R9
    idle_no_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (token == '0));
endmodule

// File: tb/sim_bin_list_merger.sv
module sim_bin_list_merger;
    localparam int NS = 16;
    localparam int NB = 4;
    localparam int TW = 16;
    localparam int CP = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [4:0] active_sectors = 5'd1;
    logic [NS-1:0] src_empty;
    logic [NS*TW-1:0] src_data;
    logic [1:0] req_bin;
    logic [NS-1:0] token, pop;
    logic out_valid, out_last, busy, truncated;
    logic [3:0] out_sector;
    logic [1:0] out_bin;
    logic [TW-1:0] out_track;

    always #4 clk = ~clk;

    bin_list_merger #(.MAX_SECTORS(NS), .NUM_BINS(NB), .TRK_W(TW), .CAP(CP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .active_sectors(active_sectors),
        .src_empty(src_empty), .src_data(src_data), .req_bin(req_bin),
        .token(token), .pop(pop), .out_valid(out_valid), .out_last(out_last),
        .out_sector(out_sector), .out_bin(out_bin), .out_track(out_track),
        .busy(busy), .truncated(truncated)
    );

    int cnt [NS][NB];
    logic [9:0] rd [NS][NB];
    logic bclr = 1'b1;

    // Sector FIFO model: payload = {sector[3:0], bin[1:0], index[9:0]}
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            src_empty[s] = (int'(rd[s][req_bin]) >= cnt[s][req_bin]);
            src_data[s*TW +: TW] = {s[3:0], req_bin, rd[s][req_bin]};
        end
    end

    always @(posedge clk) begin
        for (int s = 0; s < NS; s++)
            for (int b = 0; b < NB; b++)
                if (bclr) rd[s][b] <= '0;
                else if (pop[s] && req_bin == b[1:0]) rd[s][b] <= rd[s][b] + 10'd1;
    end

    int n_got, bcyc;
    logic [3:0] g_sec [64];
    logic [1:0] g_bin [64];
    logic [TW-1:0] g_trk [64];
    logic g_last [64];

    always @(negedge clk) begin
        if (bclr) begin
            n_got = 0;
            bcyc = 0;
        end else begin
            if (busy) bcyc++;
            if (out_valid) begin
                if (n_got < 64) begin
                    g_sec[n_got] = out_sector;
                    g_bin[n_got] = out_bin;
                    g_trk[n_got] = out_track;
                    g_last[n_got] = out_last;
                end
                n_got++;
            end
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int n, input int pat, input int seed);
        int e_n, total, wd;
        logic [3:0] e_sec [64];
        logic [1:0] e_bin [64];
        logic [TW-1:0] e_trk [64];
        bit word_ok;
        @(negedge clk);
        bclr = 1'b1;
        for (int s = 0; s < NS; s++)
            for (int b = 0; b < NB; b++) begin
                case (pat)
                    0: cnt[s][b] = 0;
                    1: cnt[s][b] = 1;
                    2: cnt[s][b] = (s*7 + b*3 + seed) % 4;
                    3: cnt[s][b] = (b == 0 && s == n-1) ? 5 : 0;
                    default: cnt[s][b] = (s == 0 && b == 3) ? 60 : ((s == 0 && b == 1) ? 2 : 0);
                endcase
            end
        // Sectors beyond the active count hold tracks that must never be read (R8)
        for (int s = n; s < NS; s++) cnt[s][0] = 3;
        active_sectors = 5'(n);
        @(negedge clk);
        bclr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wd = 0;
        while (busy && wd < 4000) begin
            @(negedge clk);
            wd++;
        end
        repeat (3) @(negedge clk);
        chk(wd < 4000, "R5 run completes", wd, 0);

        e_n = 0;
        total = 0;
        for (int b = NB-1; b >= 0; b--)
            for (int s = 0; s < n; s++)
                for (int i = 0; i < cnt[s][b]; i++) begin
                    total++;
                    if (e_n < CP) begin
                        e_sec[e_n] = s[3:0];
                        e_bin[e_n] = b[1:0];
                        e_trk[e_n] = {s[3:0], b[1:0], i[9:0]};
                        e_n++;
                    end
                end

        chk(n_got == e_n, "R3 word count", n_got, e_n);
        if (total == 0) chk(n_got == 0, "R10 empty run emits nothing", n_got, 0);
        for (int k = 0; k < e_n && k < n_got; k++) begin
            word_ok = (g_sec[k] == e_sec[k]) && (g_bin[k] == e_bin[k]);
            chk(word_ok, "R1 R6 sector/bin of word", {g_sec[k], g_bin[k]}, {e_sec[k], e_bin[k]});
            chk(g_trk[k] == e_trk[k], "R2 R6 payload order", g_trk[k], e_trk[k]);
            chk(g_last[k] == (k == e_n-1), "R3 last marker", g_last[k], (k == e_n-1));
        end
        chk(truncated == (total > CP), "R7 truncated flag", truncated, (total > CP));
        if (total < CP)
            chk(bcyc == 4*n + total + 1, "R5 busy cycles", bcyc, 4*n + total + 1);
        for (int s = n; s < NS; s++)
            chk(rd[s][0] == 10'd0, "R8 inactive sector untouched", rd[s][0], 0);
    endtask

    initial begin
        int wdog;
        wdog = 0;
        fork
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=1 expected=0");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !out_valid, "R9 idle after reset", {busy, out_valid}, 0);
        chk(token == '0 && pop == '0, "R9 no token after reset", token, 0);
        chk(!truncated, "R9 truncated clear", truncated, 0);

        run_case(13, 0, 0);
        run_case(12, 1, 0);
        run_case(13, 1, 0);
        run_case(13, 2, 0);
        run_case(14, 2, 1);
        run_case(3, 2, 2);
        run_case(1, 2, 3);
        run_case(16, 2, 1);
        run_case(14, 3, 0);
        run_case(1, 4, 0);
        run_case(2, 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule